// File: doc/BRIEF.md
# AES Coprocessor Register Front End

This block is the byte-wide register window that sits in front of a 128-bit block cipher engine. Software reaches it one byte per transfer through a simple access port, which has an address, a write byte, a read byte and a strobe. Through this port software sets the cipher mode and direction, loads and reads back the key, and fills the sixteen-byte data buffer. It starts an operation by writing the control mirror location with the launch bit set. It then polls a status byte or waits a fixed processing time before reading the result back from the same buffer.

The cipher rounds themselves live outside. The block gives the engine a one-cycle start pulse, the 128-bit input block, the key and the direction. It expects a done pulse carrying the 128-bit result. For streaming, each buffer transfer returns the byte currently held while it overwrites that byte with the next input. The result of block n can therefore be read while block n+1 is written. In chained mode, the block XORs the new input with the previous result before it hands the input to the engine. A chained stream starts with one plain (ECB) block.

Top module: `aes_regfront`

## Requirements
- R1: After reset, the status byte (0x82), the control byte (0x83), the mirror byte (0x94) and every buffer byte (0x84..0x93) read 0x00, and `eng_start` is low.
- R2: A write to 0x83 or 0x94 stores write bits [6:4] as the mode and bit 3 as the direction (0 encrypt, 1 decrypt). Both 0x83 and 0x94 then read {0, mode, dir, 000}.
- R3: A write to 0x83 never starts an operation, even when write bit 7 is set.
- R4: A write to 0x94 with bit 7 set and mode 1 (ECB) or 2 (CBC), made while idle, raises `eng_start` for exactly the one cycle after the transfer. `eng_decrypt` then equals the written direction bit, and status bit 0 reads 0 until the engine finishes.
- R5: A write to 0x94 with bit 7 set and mode 0 (KEY) or modes 3..7 (reserved) does not raise `eng_start`.
- R6: In mode 0 (KEY), buffer writes go to the key and buffer reads return the key. The data buffer is left untouched. Byte 0x84 is the most significant byte of `eng_key`.
- R7: An ECB start presents the data buffer on `eng_din`, with 0x84 as the most significant byte.
- R8: A CBC start presents the data buffer XOR the previous engine result on `eng_din`.
- R9: One cycle after an `eng_done` pulse, status bit 0 reads 1 and the buffer bytes read the engine result.
- R10: During a buffer write transfer, `acc_rdata` shows the byte held before the write. Later reads return the written byte.
- R11: While an operation is running, buffer writes, control writes and further starts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Transfer strobe, one byte per cycle |
| acc_we | input | 1 | 1 = write transfer, 0 = read transfer |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for the addressed location (old value during a write) |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_decrypt | output | 1 | Direction for the engine, 1 = decrypt |
| eng_key | output | 128 | Key block |
| eng_din | output | 128 | Input block, captured at start |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_dout | input | 128 | Result block, valid with `eng_done` |

## Verification
The assertions take two things for granted about the engine. It raises `eng_done` only while an operation is running, and only as a single-cycle pulse for each start. One assertion flags an engine that breaks the first of these. They also assume that at most one byte transfer arrives per cycle, so a control write and a launch never collide. The bench stub engine answers each start with exactly one done pulse after a fixed latency. The driver issues one transfer per cycle and waits past that latency before it touches the buffer for a new block.

// File: rtl/aes_rf_pkg.sv
package aes_rf_pkg;

    localparam int unsigned BLOCK_BYTES = 16;
    localparam int unsigned BLOCK_W     = BLOCK_BYTES * 8;
    localparam int unsigned IDX_W       = $clog2(BLOCK_BYTES);

    // Mode field codes held in control bits [6:4]
    localparam logic [2:0] MODE_KEY = 3'd0;
    localparam logic [2:0] MODE_ECB = 3'd1;
    localparam logic [2:0] MODE_CBC = 3'd2;

    typedef struct packed {
        logic             hit_status;
        logic             hit_ctrl;
        logic             hit_mirror;
        logic             hit_buf;
        logic [IDX_W-1:0] idx;
    } aes_dec_t;

endpackage

// File: rtl/aes_rf_decode.sv
module aes_rf_decode
    import aes_rf_pkg::*;
#(
    parameter logic [7:0] BASE = 8'h82
) (
    input  logic [7:0] addr,
    output aes_dec_t   dec
);
    localparam logic [7:0] A_CTRL = BASE + 8'd1;
    localparam logic [7:0] A_BUF  = BASE + 8'd2;
    localparam logic [7:0] A_MIR  = A_BUF + 8'(BLOCK_BYTES);

    always_comb begin
        dec            = '0;
        dec.hit_status = (addr == BASE);
        dec.hit_ctrl   = (addr == A_CTRL);
        dec.hit_mirror = (addr == A_MIR);
        dec.hit_buf    = (addr >= A_BUF) && (addr < A_MIR);
        dec.idx        = IDX_W'(addr - A_BUF);
    end
endmodule

// File: rtl/aes_rf_buffer.sv
module aes_rf_buffer #(
    parameter int unsigned NB = 16,
    localparam int unsigned IW = $clog2(NB),
    localparam int unsigned VW = NB * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic          load_en,
    input  logic [VW-1:0] load_val,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [VW-1:0] value
);
    logic [7:0] lane_d [NB];
    logic [7:0] lane_q [NB];

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            lane_d[i] = lane_q[i];
            if (load_en) begin
                lane_d[i] = load_val[(NB-1-i)*8 +: 8];
            end else if (wr_en && (wr_idx == IW'(i))) begin
                lane_d[i] = wr_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (!rst_n) lane_q[i] <= 8'h00;
            else        lane_q[i] <= lane_d[i];
        end
    end

    // Lane 0 is the most significant byte of the block
    for (genvar g = 0; g < NB; g++) begin : g_pack
        assign value[(NB-1-g)*8 +: 8] = lane_q[g];
    end

    assign rd_byte = lane_q[rd_idx];
endmodule

// File: rtl/aes_rf_ctrl.sv
module aes_rf_ctrl
    import aes_rf_pkg::*;
#(
    parameter int unsigned W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic         go_wr,
    input  logic [7:0]   wdata,
    input  logic [W-1:0] state_val,
    input  logic         eng_done,
    input  logic [W-1:0] eng_dout,
    output logic [2:0]   mode,
    output logic         dir,
    output logic         busy,
    output logic         done,
    output logic         eng_start,
    output logic [W-1:0] eng_din,
    output logic         load_en
);
    typedef struct packed {
        logic [2:0]   mode;
        logic         dir;
        logic         busy;
        logic         done;
        logic         start;
        logic [W-1:0] din;
        logic [W-1:0] prev;
    } regs_t;

    regs_t q, d;
    logic [2:0] new_mode;
    logic       mode_ok;

    assign new_mode = wdata[6:4];
    assign mode_ok  = (new_mode == MODE_ECB) || (new_mode == MODE_CBC);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (!q.busy) begin
            if (cfg_wr) begin
                d.mode = new_mode;
                d.dir  = wdata[3];
            end
            if (go_wr && wdata[7] && mode_ok) begin
                d.busy  = 1'b1;
                d.done  = 1'b0;
                d.start = 1'b1;
                d.din   = (new_mode == MODE_CBC) ? (state_val ^ q.prev) : state_val;
            end
        end else if (eng_done) begin
            d.busy = 1'b0;
            d.done = 1'b1;
            d.prev = eng_dout;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode      = q.mode;
    assign dir       = q.dir;
    assign busy      = q.busy;
    assign done      = q.done;
    assign eng_start = q.start;
    assign eng_din   = q.din;
    assign load_en   = q.busy && eng_done;
endmodule

// File: rtl/aes_regfront.sv
module aes_regfront
    import aes_rf_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h82
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_stb,
    input  logic               acc_we,
    input  logic [7:0]         acc_addr,
    input  logic [7:0]         acc_wdata,
    output logic [7:0]         acc_rdata,
    output logic               eng_start,
    output logic               eng_decrypt,
    output logic [BLOCK_W-1:0] eng_key,
    output logic [BLOCK_W-1:0] eng_din,
    input  logic               eng_done,
    input  logic [BLOCK_W-1:0] eng_dout
);
    aes_dec_t           dec;
    logic               wr_xfer;
    logic               buf_wr;
    logic               key_sel;
    logic [2:0]         mode_w;
    logic               dir_w;
    logic               busy_w;
    logic               done_w;
    logic               load_w;
    logic [7:0]         state_byte;
    logic [7:0]         key_byte;
    logic [7:0]         ctrl_byte;
    logic [BLOCK_W-1:0] state_val;

    aes_rf_decode #(.BASE(BASE_ADDR)) u_dec (
        .addr (acc_addr),
        .dec  (dec)
    );

    assign wr_xfer = acc_stb && acc_we;
    assign key_sel = (mode_w == MODE_KEY);
    assign buf_wr  = wr_xfer && dec.hit_buf && !busy_w;

    aes_rf_ctrl #(.W(BLOCK_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wr_xfer && (dec.hit_ctrl || dec.hit_mirror)),
        .go_wr     (wr_xfer && dec.hit_mirror),
        .wdata     (acc_wdata),
        .state_val (state_val),
        .eng_done  (eng_done),
        .eng_dout  (eng_dout),
        .mode      (mode_w),
        .dir       (dir_w),
        .busy      (busy_w),
        .done      (done_w),
        .eng_start (eng_start),
        .eng_din   (eng_din),
        .load_en   (load_w)
    );

    aes_rf_buffer #(.NB(BLOCK_BYTES)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr && !key_sel),
        .wr_idx   (dec.idx),
        .wr_byte  (acc_wdata),
        .load_en  (load_w),
        .load_val (eng_dout),
        .rd_idx   (dec.idx),
        .rd_byte  (state_byte),
        .value    (state_val)
    );

    aes_rf_buffer #(.NB(BLOCK_BYTES)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr && key_sel),
        .wr_idx   (dec.idx),
        .wr_byte  (acc_wdata),
        .load_en  (1'b0),
        .load_val ('0),
        .rd_idx   (dec.idx),
        .rd_byte  (key_byte),
        .value    (eng_key)
    );

    assign ctrl_byte   = {1'b0, mode_w, dir_w, 3'b000};
    assign eng_decrypt = dir_w;

    always_comb begin
        acc_rdata = 8'h00;
        if (dec.hit_status)                      acc_rdata = {7'b0, done_w};
        else if (dec.hit_ctrl || dec.hit_mirror) acc_rdata = ctrl_byte;
        else if (dec.hit_buf)                    acc_rdata = key_sel ? key_byte : state_byte;
    end
endmodule

// File: rtl/aes_rf_checker.sv
module aes_rf_checker
    import aes_rf_pkg::*;
#(
    parameter logic [7:0] BASE = 8'h82
) (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_stb,
    input logic       acc_we,
    input logic [7:0] acc_addr,
    input logic [7:0] acc_wdata,
    input logic       eng_start,
    input logic       eng_done,
    input logic       busy,
    input logic       done
);
    localparam logic [7:0] A_CTRL = BASE + 8'd1;
    localparam logic [7:0] A_MIR  = BASE + 8'd2 + 8'(BLOCK_BYTES);

    logic mir_wr, launch_ok;
    assign mir_wr    = acc_stb && acc_we && (acc_addr == A_MIR);
    assign launch_ok = acc_wdata[7] &&
                       ((acc_wdata[6:4] == MODE_ECB) || (acc_wdata[6:4] == MODE_CBC));

    // R4: valid launch while idle gives a start in the next cycle
    a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_wr && launch_ok && !busy) |=> eng_start);

    // R4: start is a single-cycle pulse, with done cleared and busy set
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    a_r4_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (busy && !done));

    // R5: reserved or KEY mode on the mirror gives no start
    a_r5_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_wr && !launch_ok) |=> !eng_start);

    // R3: control writes never start
    a_r3_cfg_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && acc_we && (acc_addr == A_CTRL)) |=> !eng_start);

    // R9: engine completion sets done and leaves busy
    a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> (done && !busy));

    // R11: no second start while an operation runs
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !eng_start);

    // Environment: the engine answers only while busy
    a_r9_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> busy);
endmodule

bind aes_regfront aes_rf_checker #(.BASE(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_stb   (acc_stb),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .busy      (busy_w),
    .done      (done_w)
);

// File: tb/test_aes_regfront.sv
module test_aes_regfront;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         acc_stb, acc_we;
    logic [7:0]   acc_addr, acc_wdata, acc_rdata;
    logic         eng_start, eng_decrypt, eng_done;
    logic [127:0] eng_key, eng_din, eng_dout;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sbq[$];
    logic mon_chk;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_regfront i_aes_regfront (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .eng_start(eng_start), .eng_decrypt(eng_decrypt), .eng_key(eng_key),
        .eng_din(eng_din), .eng_done(eng_done), .eng_dout(eng_dout)
    );

    function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] k,
                                           input logic dec);
        return {d[119:0], d[127:120]} ^ k ^ {128{dec}};
    endfunction

    function automatic logic [7:0] bsel(input logic [127:0] v, input int i);
        return v[(15-i)*8 +: 8];
    endfunction

    // Stub engine
    int           cnt;
    logic [127:0] cap;
    logic         capdec;
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0; eng_done <= 1'b0; eng_dout <= '0;
        end else begin
            eng_done <= 1'b0;
            if (eng_start) begin
                cnt <= LAT; cap <= eng_din; capdec <= eng_decrypt;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    eng_done <= 1'b1;
                    eng_dout <= model(cap, eng_key, capdec);
                end
            end
        end
    end

    // Monitor: pops the scoreboard on every checked transfer
    always @(negedge clk) begin
        exp_t e;
        if (mon_chk) begin
            e = sbq.pop_front();
            checks++;
            if (acc_rdata !== e.exp) begin
                errors++;
                $display("FAIL %s addr %h rdata %h expected %h", e.tag, acc_addr, acc_rdata, e.exp);
            end
        end
    end

    task automatic xfer(input logic we, input logic [7:0] a, input logic [7:0] wd,
                        input logic chk, input logic [7:0] ex, input string tag);
        if (chk) sbq.push_back('{exp: ex, tag: tag});
        acc_stb = 1'b1; acc_we = we; acc_addr = a; acc_wdata = wd; mon_chk = chk;
        @(posedge clk); #1;
        acc_stb = 1'b0; acc_we = 1'b0; mon_chk = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] wd);
        xfer(1'b1, a, wd, 1'b0, 8'h00, "");
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] ex, input string tag);
        xfer(1'b0, a, 8'h00, 1'b1, ex, tag);
    endtask

    task automatic wrrd(input logic [7:0] a, input logic [7:0] wd, input logic [7:0] ex,
                        input string tag);
        xfer(1'b1, a, wd, 1'b1, ex, tag);
    endtask

    task automatic chk(input logic [127:0] act, input logic [127:0] ex, input string tag);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, ex);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    localparam logic [127:0] KEY = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    localparam logic [127:0] P1  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] P2  = 128'hdeadbeef01020304a5a55a5a13579bdf;
    localparam logic [127:0] P3  = 128'h0123456789abcdeffedcba9876543210;

    initial begin
        logic [127:0] c1, c2, c3;
        rst_n = 1'b0; acc_stb = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
        mon_chk = 1'b0;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h82, 8'h00, "R1 status");
        rd(8'h83, 8'h00, "R1 ctrl");
        rd(8'h94, 8'h00, "R1 mirror");
        rd(8'h8b, 8'h00, "R1 buffer");
        chk(128'(eng_start), 128'(0), "R1 eng_start");

        // R2 field storage and mirror
        wr(8'h83, 8'hff);
        rd(8'h83, 8'h78, "R2 ctrl masked");
        rd(8'h94, 8'h78, "R2 mirror equals ctrl");

        // R6 key load and readback
        wr(8'h83, 8'h00);
        for (int i = 0; i < 16; i++) wr(8'h84 + 8'(i), bsel(KEY, i));
        for (int i = 0; i < 16; i++) rd(8'h84 + 8'(i), bsel(KEY, i), "R6 key readback");
        chk(eng_key, KEY, "R6 eng_key order");

        // R3 control write with bit 7 does not start
        wr(8'h83, 8'h90);
        chk(128'(eng_start), 128'(0), "R3 no start from ctrl");
        rd(8'h83, 8'h10, "R3 ctrl value");

        // R5 reserved and KEY launch attempts
        wr(8'h94, 8'h80);
        chk(128'(eng_start), 128'(0), "R5 KEY mode launch");
        wr(8'h94, 8'hb0);
        chk(128'(eng_start), 128'(0), "R5 mode 3 launch");
        wr(8'h94, 8'hf8);
        chk(128'(eng_start), 128'(0), "R5 mode 7 launch");

        // R10 and R6: data buffer untouched by key writes, streams old bytes
        wr(8'h83, 8'h10);
        for (int i = 0; i < 16; i++) wrrd(8'h84 + 8'(i), bsel(P1, i), 8'h00, "R10 R6 old byte");
        rd(8'h84, bsel(P1, 0), "R10 new byte");

        // R4 R7 ECB start
        wr(8'h94, 8'h90);
        chk(128'(eng_start), 128'(1), "R4 start pulse");
        chk(eng_din, P1, "R7 ecb din");
        chk(128'(eng_decrypt), 128'(0), "R4 direction");
        rd(8'h82, 8'h00, "R4 status busy");
        chk(128'(eng_start), 128'(0), "R4 single pulse");

        // R11 writes ignored while busy
        wrrd(8'h84, 8'haa, bsel(P1, 0), "R11 buffer old");
        rd(8'h84, bsel(P1, 0), "R11 buffer write ignored");
        wr(8'h83, 8'h38);
        wr(8'h94, 8'ha8);
        chk(128'(eng_start), 128'(0), "R11 no restart");
        rd(8'h83, 8'h10, "R11 ctrl write ignored");

        // R9 completion
        idle(LAT + 6);
        c1 = model(P1, KEY, 1'b0);
        rd(8'h82, 8'h01, "R9 status done");

        // R10 R9 stream next block while reading result
        for (int i = 0; i < 16; i++) wrrd(8'h84 + 8'(i), bsel(P2, i), bsel(c1, i), "R9 R10 result");

        // R8 CBC encrypt
        wr(8'h94, 8'ha0);
        chk(128'(eng_start), 128'(1), "R8 start");
        chk(eng_din, P2 ^ c1, "R8 cbc din");
        idle(LAT + 6);
        c2 = model(P2 ^ c1, KEY, 1'b0);
        for (int i = 0; i < 16; i++) wrrd(8'h84 + 8'(i), bsel(P3, i), bsel(c2, i), "R10 cbc result");

        // R8 R4 CBC with decrypt direction
        wr(8'h94, 8'ha8);
        chk(eng_din, P3 ^ c2, "R8 cbc chain din");
        chk(128'(eng_decrypt), 128'(1), "R4 decrypt dir");
        rd(8'h83, 8'h28, "R2 ctrl after launch");
        idle(LAT + 6);
        c3 = model(P3 ^ c2, KEY, 1'b1);
        rd(8'h82, 8'h01, "R9 status done");
        for (int i = 0; i < 16; i++) rd(8'h84 + 8'(i), bsel(c3, i), "R9 result");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule